// File: doc/BRIEF.md
# Push-Down Program Counter Stack

This block holds the program address of a small 8-bit processor core. The program counter is not a register of its own: it is whichever of eight 14-bit slots a 3-bit level pointer selects. The slots together form a register file. A subroutine call moves the pointer up one slot and writes the target into that slot. The caller's address stays in the slot below. A return moves the pointer down one slot, so no address is copied on either operation. This gives seven nested return levels in addition to the running address.

The sequencer of the core drives one request per instruction step:
- increment, for a fetch;
- jump, with a target;
- call, with a target;
- return;
- restart, with a 3-bit vector number. A restart calls the fixed entry point at eight times the vector number.

A built-in condition evaluator tests one of the carry, zero, sign and parity flags against a sense bit. When the conditional qualifier is high, calls, returns and jumps take effect only if the evaluated condition is true. Restarts are always unconditional. Nesting past seven levels, and returning with nothing saved, both wrap the pointer modulo eight without any indication.

Top module: `pushdown_pc_stack`

## Requirements
- R1: After reset the PC output is 0, the level pointer is at slot 0 and all eight slots hold 0. A return issued straight after reset therefore yields address 0.
- R2: When `pc_inc` is high and no other operation takes effect, the PC advances by one at the next clock edge and wraps from 3FFFh to 0.
- R3: A taken jump loads `jmp_addr` into the current slot and leaves the nesting level unchanged.
- R4: A taken call makes the PC equal to `call_addr` after the clock edge. The next return restores the address the PC held before the call. `call_req` and `ret_req` are never high in the same cycle.
- R5: Seven nested calls followed by seven returns give back the saved addresses in last-in, first-out order.
- R6: A restart with vector N (0 to 7) saves the PC and sets the PC to N×8, so the entry points are 00h, 08h, up to 38h.
- R7: `cond_ok` is 1 when the selected flag equals `cond_code[2]`. The selector `cond_code[1:0]` picks 00 = carry, 01 = zero, 10 = sign and 11 = parity, where a parity flag of 1 means even parity.
- R8: With `cond_en` high and `cond_ok` low, a call, return or jump has no effect. A restart still takes effect.
- R9: When several requests are high together, only the highest-priority taken one acts. The order is call, restart, return, jump, increment. An increment is dropped whenever any control operation is taken.
- R10: An eighth nested call wraps the pointer to slot 0 and overwrites that slot. The following returns walk down through slots 7 to 0.
- R11: A return at level 0 wraps the pointer to slot 7 and makes the PC equal to that slot's content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_inc | input | 1 | Advance PC by one |
| jmp_req | input | 1 | Jump request |
| jmp_addr | input | 14 | Jump target |
| call_req | input | 1 | Call request |
| call_addr | input | 14 | Call target |
| ret_req | input | 1 | Return request |
| vec_req | input | 1 | Restart request |
| vec_num | input | 3 | Restart vector number |
| cond_en | input | 1 | Qualify call, return and jump by the condition |
| cond_code | input | 3 | Bit 2 sense, bits 1:0 flag selector |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| flag_s | input | 1 | Sign flag |
| flag_p | input | 1 | Parity flag (1 = even) |
| pc | output | 14 | Current program address |
| cond_ok | output | 1 | Evaluated condition |

## Verification
A wrong pointer step or a misdirected slot write does not always change the PC right away. It shows up at the PC output on the first return that reads the damaged or wrong slot, which may be several calls later. For that reason the bench nests calls fully, across the wrap at eight levels, and unwinds every level. It compares the PC against a reference model after every clock edge. An error in the condition evaluator or in the gating of a request shows on `cond_ok` in the same cycle, and on the PC one edge later.

// File: rtl/pushdown_pc_stack.sv
module pushdown_pc_stack #(
  parameter int AW     = 14,
  parameter int DEPTH  = 8,
  parameter int VW     = 3,
  parameter int VSHIFT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pc_inc,
  input  logic          jmp_req,
  input  logic [AW-1:0] jmp_addr,
  input  logic          call_req,
  input  logic [AW-1:0] call_addr,
  input  logic          ret_req,
  input  logic          vec_req,
  input  logic [VW-1:0] vec_num,
  input  logic          cond_en,
  input  logic [2:0]    cond_code,
  input  logic          flag_c,
  input  logic          flag_z,
  input  logic          flag_s,
  input  logic          flag_p,
  output logic [AW-1:0] pc,
  output logic          cond_ok
);
  localparam int LW  = $clog2(DEPTH);
  localparam int PAD = AW - VW - VSHIFT;

  logic [AW-1:0] slot [DEPTH];
  logic [LW-1:0] lvl;
  logic [LW-1:0] lvl_up, lvl_dn;
  logic [AW-1:0] vec_tgt;
  logic          sel_flag, go;
  logic          do_call, do_vec, do_ret, do_jmp;

  always_comb begin
    case (cond_code[1:0])
      2'b00:   sel_flag = flag_c;
      2'b01:   sel_flag = flag_z;
      2'b10:   sel_flag = flag_s;
      default: sel_flag = flag_p;
    endcase
  end

  assign cond_ok = (sel_flag == cond_code[2]);
  assign go      = !cond_en || cond_ok;

  assign do_call = call_req && go;
  assign do_vec  = vec_req && !do_call;
  assign do_ret  = ret_req && go && !do_call && !do_vec;
  assign do_jmp  = jmp_req && go && !do_call && !do_vec && !do_ret;

  assign lvl_up  = lvl + 1'b1;
  assign lvl_dn  = lvl - 1'b1;
  assign vec_tgt = {{PAD{1'b0}}, vec_num, {VSHIFT{1'b0}}};
  assign pc      = slot[lvl];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl <= '0;
      for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
    end else if (do_call) begin
      lvl <= lvl_up;
      slot[lvl_up] <= call_addr;
    end else if (do_vec) begin
      lvl <= lvl_up;
      slot[lvl_up] <= vec_tgt;
    end else if (do_ret) begin
      lvl <= lvl_dn;
    end else if (do_jmp) begin
      slot[lvl] <= jmp_addr;
    end else if (pc_inc) begin
      slot[lvl] <= slot[lvl] + 1'b1;
    end
  end

  assert_no_call_ret_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(call_req && ret_req));

  assert_call_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (call_req && go) |=> pc == $past(call_addr));

  assert_vector_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_req && !(call_req && go)) |=> (pc[VSHIFT-1:0] == '0 && (pc >> (VW + VSHIFT)) == '0));

  assert_increment_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_inc && !vec_req && !(go && (call_req || ret_req || jmp_req)))
      |=> pc == AW'($past(pc) + 1'b1));

  assert_cond_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_en && !cond_ok && !vec_req && !pc_inc) |=> $stable(pc));
endmodule

// File: tb/sim_pushdown_pc_stack.sv
module sim_pushdown_pc_stack;
  logic        clk = 0, rst_n = 0;
  logic        pc_inc = 0, jmp_req = 0, call_req = 0, ret_req = 0, vec_req = 0;
  logic [13:0] jmp_addr = 0, call_addr = 0;
  logic [2:0]  vec_num = 0, cond_code = 0;
  logic        cond_en = 0, flag_c = 0, flag_z = 0, flag_s = 0, flag_p = 0;
  logic [13:0] pc;
  logic        cond_ok;

  int total = 0, bad = 0;
  int m_slot [8];
  int m_lvl = 0;

  always #5 clk = ~clk;

  pushdown_pc_stack u0 (
    .clk(clk), .rst_n(rst_n), .pc_inc(pc_inc), .jmp_req(jmp_req), .jmp_addr(jmp_addr),
    .call_req(call_req), .call_addr(call_addr), .ret_req(ret_req), .vec_req(vec_req),
    .vec_num(vec_num), .cond_en(cond_en), .cond_code(cond_code), .flag_c(flag_c),
    .flag_z(flag_z), .flag_s(flag_s), .flag_p(flag_p), .pc(pc), .cond_ok(cond_ok));

  function automatic bit exp_cond();
    bit f;
    case (cond_code[1:0])
      2'd0: f = flag_c;
      2'd1: f = flag_z;
      2'd2: f = flag_s;
      default: f = flag_p;
    endcase
    return f == cond_code[2];
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(string tag);
    bit go;
    #1;
    check({tag, " cond_ok"}, cond_ok, exp_cond());
    go = !cond_en || exp_cond();
    @(posedge clk);
    if (call_req && go) begin
      m_lvl = (m_lvl + 1) % 8; m_slot[m_lvl] = call_addr;
    end else if (vec_req) begin
      m_lvl = (m_lvl + 1) % 8; m_slot[m_lvl] = vec_num * 8;
    end else if (ret_req && go) begin
      m_lvl = (m_lvl + 7) % 8;
    end else if (jmp_req && go) begin
      m_slot[m_lvl] = jmp_addr;
    end else if (pc_inc) begin
      m_slot[m_lvl] = (m_slot[m_lvl] + 1) % 16384;
    end
    @(negedge clk);
    check({tag, " pc"}, pc, m_slot[m_lvl]);
    pc_inc = 0; jmp_req = 0; call_req = 0; ret_req = 0; vec_req = 0; cond_en = 0;
  endtask

  task automatic do_call(string tag, int a);
    call_req = 1; call_addr = 14'(a); tick(tag);
  endtask
  task automatic do_ret(string tag);
    ret_req = 1; tick(tag);
  endtask
  task automatic do_jmp(string tag, int a);
    jmp_req = 1; jmp_addr = 14'(a); tick(tag);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m_slot[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 reset pc", pc, 0);
    do_ret("R1 return after reset");
    do_call("R1 restore level", 14'h0055);
    do_ret("R1 back to slot 7");

    for (int i = 0; i < 3; i++) begin pc_inc = 1; tick("R2 increment"); end
    do_jmp("R3 jump near top", 14'h3FFE);
    pc_inc = 1; tick("R2 increment");
    pc_inc = 1; tick("R2 wrap to zero");
    do_jmp("R3 jump", 14'h0123);

    do_call("R4 call", 14'h0200);
    pc_inc = 1; tick("R4 inc inside callee");
    do_ret("R4 return restores caller");
    check("R4 caller address", pc, 14'h0123);

    for (int i = 1; i <= 7; i++) do_call("R5 nest", 14'h1000 + i * 17);
    for (int i = 0; i < 7; i++) do_ret("R5 unwind");
    check("R5 back at base", pc, 14'h0123);

    for (int n = 0; n < 8; n++) begin
      vec_req = 1; vec_num = 3'(n); tick("R6 restart");
      check("R6 entry point", pc, n * 8);
      do_ret("R6 return from restart");
    end

    for (int c = 0; c < 8; c++)
      for (int f = 0; f < 16; f++) begin
        cond_code = 3'(c);
        {flag_c, flag_z, flag_s, flag_p} = 4'(f);
        tick("R7 evaluator");
      end

    cond_code = 3'b100; flag_c = 0;
    cond_en = 1; call_req = 1; call_addr = 14'h0777; tick("R8 call not taken");
    cond_en = 1; jmp_req = 1; jmp_addr = 14'h0666; tick("R8 jump not taken");
    cond_en = 1; ret_req = 1; tick("R8 return not taken");
    cond_en = 1; vec_req = 1; vec_num = 3'd5; tick("R8 restart ignores condition");
    flag_c = 1;
    cond_en = 1; ret_req = 1; tick("R8 return taken");
    cond_en = 1; call_req = 1; call_addr = 14'h0321; tick("R8 call taken");
    cond_en = 1; jmp_req = 1; jmp_addr = 14'h0322; tick("R8 jump taken");
    cond_code = 3'b011; flag_p = 1;
    cond_en = 1; ret_req = 1; tick("R8 parity odd not taken");

    call_req = 1; call_addr = 14'h0AAA; pc_inc = 1; tick("R9 call over inc");
    call_req = 1; call_addr = 14'h0BBB; vec_req = 1; vec_num = 3'd2; tick("R9 call over restart");
    vec_req = 1; vec_num = 3'd7; ret_req = 1; tick("R9 restart over return");
    ret_req = 1; jmp_req = 1; jmp_addr = 14'h0CCC; tick("R9 return over jump");
    jmp_req = 1; jmp_addr = 14'h0DDD; pc_inc = 1; tick("R9 jump over inc");

    rst_n = 0; @(negedge clk); rst_n = 1;
    m_lvl = 0; for (int i = 0; i < 8; i++) m_slot[i] = 0;
    check("R1 second reset", pc, 0);
    do_jmp("R10 base", 14'h0042);
    for (int i = 1; i <= 8; i++) do_call("R10 overflow call", 14'h2000 + i);
    check("R10 eighth target", pc, 14'h2008);
    for (int i = 0; i < 8; i++) do_ret("R10 wrapped unwind");
    check("R10 slot 0 overwritten", pc, 14'h2008);
    do_ret("R11 underflow to slot 7");
    check("R11 slot 7 content", pc, 14'h2007);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule